// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a direct-mapped data cache that sits between a pipeline's memory stage and a main-memory port. It works on 30-bit physical byte addresses and serves aligned 32-bit loads and stores. Each line holds four words. Each line also keeps a tag, a valid bit and a dirty bit. A load that hits returns its word in the same cycle. A miss starts a refill sequence. If the victim line is dirty in write-back mode, the sequence first writes that line back to memory. It then fetches the new 128-bit block, installs it, and re-runs the original access, which now hits.

The parameter `WRITE_BACK` selects the store policy. When it is 1, a store hit changes only the cache and marks the line dirty. When it is 0 (write-through), every store also sends its word to memory, and no line ever becomes dirty. A store that misses allocates the line first and then completes as a hit. The requester must hold its request inputs stable until `cpu_ready` is high. The default `INDEX_W` of 6 gives 64 lines. `INDEX_W` = 13 gives the full 128 KiB arrangement with a 13-bit tag. `rst_n` is asynchronous, and its release is expected to be synchronous to `clk`.

Top module: `dmap_dcache`

## Requirements
- R1: Address fields: the tag is bits [29:4+INDEX_W], the line index is bits [3+INDEX_W:4], the word select is bits [3:2], and bits [1:0] must be zero. Two addresses that differ only in the word select share one line. Two addresses that differ only in the tag compete for the same line.
- R2: Reset clears every valid and dirty bit. After reset, `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R3: A load hit raises `cpu_ready` in the same cycle as the request, drives the stored word on `cpu_rdata`, and issues no memory transaction.
- R4: On a miss, the cache issues one block read (`mem_we`=0) at the requested address with bits [3:0] cleared. It installs `mem_rdata` with the new tag and sets the line valid. It then retries the access, and the retry hits.
- R5: `mem_req`, `mem_we`, `mem_addr`, `mem_wdata` and `mem_wmask` stay stable from the rise of `mem_req` until the cycle in which `mem_ack` is high. Each transaction moves one 128-bit block lane set. Word k sits in `mem_wdata[32k+31:32k]`.
- R6: Write-through store: the word is written into the cache and sent to memory in one transaction. That transaction has `mem_we`=1 and `mem_wmask` with only bit k set, where k is address bits [3:2]. The word appears in lane k. `cpu_ready` rises in the cycle that `mem_ack` is high.
- R7: Write-back store hit: the word is written into the cache, the line is marked dirty, and `cpu_ready` is high in the same cycle. No memory transaction is issued.
- R8: Write-back miss on a valid dirty line: the cache first writes the whole old line with `mem_wmask`=4'b1111 to the address {stored tag, index, 4'b0000}. Only after that does it issue the refill read.
- R9: A store miss allocates. It refills the line as in R4 and then performs the store as a hit under the selected policy.
- R10: A refill leaves the line clean. A miss on a clean or invalid line costs exactly one read. In write-through mode no line is ever dirty, so no writeback ever happens.
- R11: While a miss or a write-through store is in progress, `cpu_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Physical byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = block read |
| mem_addr | output | ADDR_W | Block address, bits [3:0] zero |
| mem_wdata | output | 128 | Write data, word k in lane k |
| mem_wmask | output | 4 | Per-word write enable |
| mem_ack | input | 1 | One-cycle completion pulse |
| mem_rdata | input | 128 | Read block, valid with `mem_ack` |

## Verification
A load or write-back store that hits must show `cpu_ready` in the very cycle its request is driven, with zero memory transactions. The bench therefore samples `cpu_ready` one time unit after driving the request and requires that no extra cycle passes. Every other result depends on the memory latency: a miss completes one cycle after the refill acknowledge, and a write-through store completes in its acknowledge cycle. For these cases the bench waits for `cpu_ready` and checks how many memory transactions were spent against the count its own model of the line states predicts (0, 1 or 2). The memory model is read only after the clock edge that commits the write, and a separate monitor checks at every falling edge that a pending request is neither dropped nor changed before its acknowledge.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int LINE_W     = WORD_W * LINE_WORDS;
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int OFS_W      = WSEL_W + 2;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WRITEBACK = 3'd1,
    ST_REFILL    = 3'd2,
    ST_RETRY     = 3'd3,
    ST_WTSTORE   = 3'd4
  } dc_state_e;
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
  parameter int INDEX_W    = 6,
  parameter int TAG_W      = 20,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               set_dirty,
  output logic               rd_valid,
  output logic               rd_dirty,
  output logic [TAG_W-1:0]   rd_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (set_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];

  // R10: write-through mode never holds a dirty line
  assert_wt_never_dirty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITE_BACK |-> !rd_dirty);
endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store import dcache_pkg::*; #(
  parameter int INDEX_W = 6
) (
  input  logic              clk,
  input  logic [INDEX_W-1:0] idx,
  input  logic [WSEL_W-1:0] word_sel,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output logic [LINE_W-1:0] rd_line,
  output logic [WORD_W-1:0] rd_word
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINE_W-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      line_q[idx] <= fill_line;
    end else if (wr_en) begin
      for (int k = 0; k < LINE_WORDS; k++) begin
        if (word_sel == WSEL_W'(k)) line_q[idx][k*WORD_W +: WORD_W] <= wr_word;
      end
    end
  end

  assign rd_line = line_q[idx];

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < LINE_WORDS; k++) begin
      if (word_sel == WSEL_W'(k)) rd_word = rd_line[k*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl import dcache_pkg::*; #(
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cpu_req,
  input  logic      cpu_we,
  input  logic      hit,
  input  logic      victim_dirty,
  input  logic      mem_ack,
  output dc_state_e state,
  output logic      cpu_ready,
  output logic      mem_req,
  output logic      mem_we,
  output logic      fill_en,
  output logic      wr_en,
  output logic      set_dirty
);
  dc_state_e state_q, state_d;
  logic      serve;
  logic      wt_store;

  assign serve    = ((state_q == ST_IDLE) || (state_q == ST_RETRY)) && cpu_req && hit;
  assign wt_store = cpu_we && !WRITE_BACK;

  always_comb begin
    state_d   = state_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    fill_en   = 1'b0;
    wr_en     = 1'b0;
    set_dirty = 1'b0;
    cpu_ready = 1'b0;
    case (state_q)
      ST_IDLE, ST_RETRY: begin
        if (serve) begin
          if (wt_store) begin
            state_d = ST_WTSTORE;
          end else begin
            cpu_ready = 1'b1;
            wr_en     = cpu_we;
            set_dirty = cpu_we;
            state_d   = ST_IDLE;
          end
        end else if (cpu_req) begin
          state_d = (WRITE_BACK && victim_dirty) ? ST_WRITEBACK : ST_REFILL;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_WRITEBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) state_d = ST_REFILL;
      end
      ST_REFILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          fill_en = 1'b1;
          state_d = ST_RETRY;
        end
      end
      ST_WTSTORE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          wr_en     = 1'b1;
          cpu_ready = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R5: a pending memory request is held until acknowledged
  assert_mem_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);
  // R4: the access retried after a refill hits
  assert_retry_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RETRY) |-> hit);
  // R11: no completion while a block transfer is outstanding without acknowledge
  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |-> !cpu_ready);
endmodule

// File: rtl/dmap_dcache.sv
module dmap_dcache import dcache_pkg::*; #(
  parameter int ADDR_W     = 30,
  parameter int INDEX_W    = 6,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  output logic [LINE_WORDS-1:0] mem_wmask,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - INDEX_W - OFS_W;

  logic [TAG_W-1:0]   a_tag;
  logic [INDEX_W-1:0] a_idx;
  logic [WSEL_W-1:0]  a_word;
  logic               rd_valid, rd_dirty, hit;
  logic [TAG_W-1:0]   rd_tag;
  logic [LINE_W-1:0]  rd_line;
  logic               fill_en, wr_en, set_dirty;
  dc_state_e          state;

  assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_idx  = cpu_addr[OFS_W +: INDEX_W];
  assign a_word = cpu_addr[2 +: WSEL_W];
  assign hit    = rd_valid && (rd_tag == a_tag);

  dcache_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(a_idx), .fill_en(fill_en), .fill_tag(a_tag),
    .set_dirty(set_dirty), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag));

  dcache_data_store #(.INDEX_W(INDEX_W)) u_data (
    .clk(clk), .idx(a_idx), .word_sel(a_word), .fill_en(fill_en), .fill_line(mem_rdata),
    .wr_en(wr_en), .wr_word(cpu_wdata), .rd_line(rd_line), .rd_word(cpu_rdata));

  dcache_ctrl #(.WRITE_BACK(WRITE_BACK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .hit(hit),
    .victim_dirty(rd_valid && rd_dirty), .mem_ack(mem_ack), .state(state),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we), .fill_en(fill_en),
    .wr_en(wr_en), .set_dirty(set_dirty));

  always_comb begin
    mem_addr  = {cpu_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    mem_wdata = {LINE_WORDS{cpu_wdata}};
    mem_wmask = '0;
    if (state == ST_WRITEBACK) begin
      mem_addr  = {rd_tag, a_idx, {OFS_W{1'b0}}};
      mem_wdata = rd_line;
      mem_wmask = '1;
    end else if (state == ST_WTSTORE) begin
      mem_wmask = LINE_WORDS'(1) << a_word;
    end
  end

  // R1: requests are word aligned
  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_addr[1:0] == 2'b00));
  // R3: a load hit from idle completes at once with no memory traffic
  assert_load_hit_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cpu_req && !cpu_we && hit) |-> (cpu_ready && !mem_req));
  // R5: request fields stay stable until acknowledged
  assert_mem_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wmask)));
  // R6: write-through writes carry exactly one word
  assert_wt_one_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITE_BACK && mem_req && mem_we) |-> ($countones(mem_wmask) == 1));
  // R7: write-back store hit completes without memory traffic
  assert_wb_store_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK && state == ST_IDLE && cpu_req && cpu_we && hit) |-> (cpu_ready && !mem_req));
  // R8: the victim written back belongs to a different tag
  assert_victim_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITEBACK) |-> (mem_addr[ADDR_W-1 -: TAG_W] != a_tag && mem_wmask == '1));
endmodule

// File: tb/dmap_dcache_bench.sv
`timescale 1ns/1ps
module dcache_mem_model (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         we,
  input  logic [29:0]  addr,
  input  logic [127:0] wdata,
  input  logic [3:0]   wmask,
  output logic         ack,
  output logic [127:0] rdata
);
  logic [127:0] mem [256];
  int           ntx;
  int           cnt;
  int           lat;

  function automatic logic [31:0] pat(int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  initial begin
    for (int l = 0; l < 256; l++)
      for (int k = 0; k < 4; k++) mem[l][k*32 +: 32] = pat(l*4 + k);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; cnt <= 0; lat <= 1; ntx <= 0; rdata <= '0;
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        if (cnt >= lat) begin
          ack <= 1'b1;
          cnt <= 0;
          lat <= $urandom_range(0, 3);
          ntx <= ntx + 1;
          if (we) begin
            for (int k = 0; k < 4; k++)
              if (wmask[k]) mem[addr[11:4]][k*32 +: 32] <= wdata[k*32 +: 32];
          end else begin
            rdata <= mem[addr[11:4]];
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end
endmodule

module dmap_dcache_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, sel, req, we;
  logic [29:0]  addr;
  logic [31:0]  wdata;
  logic         rdy_b, rdy_t, mreq_b, mreq_t, mwe_b, mwe_t, ack_b, ack_t;
  logic [31:0]  rdata_b, rdata_t;
  logic [29:0]  maddr_b, maddr_t;
  logic [127:0] mwd_b, mwd_t, mrd_b, mrd_t;
  logic [3:0]   mwm_b, mwm_t;

  dmap_dcache #(.WRITE_BACK(1'b1)) u_dmap_dcache (
    .clk(clk), .rst_n(rst_n), .cpu_req(req && !sel), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_rdata(rdata_b), .cpu_ready(rdy_b), .mem_req(mreq_b),
    .mem_we(mwe_b), .mem_addr(maddr_b), .mem_wdata(mwd_b), .mem_wmask(mwm_b),
    .mem_ack(ack_b), .mem_rdata(mrd_b));
  dcache_mem_model u_mem_b (.clk(clk), .rst_n(rst_n), .req(mreq_b), .we(mwe_b),
    .addr(maddr_b), .wdata(mwd_b), .wmask(mwm_b), .ack(ack_b), .rdata(mrd_b));

  dmap_dcache #(.WRITE_BACK(1'b0)) u_dmap_dcache_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(req && sel), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_rdata(rdata_t), .cpu_ready(rdy_t), .mem_req(mreq_t),
    .mem_we(mwe_t), .mem_addr(maddr_t), .mem_wdata(mwd_t), .mem_wmask(mwm_t),
    .mem_ack(ack_t), .mem_rdata(mrd_t));
  dcache_mem_model u_mem_t (.clk(clk), .rst_n(rst_n), .req(mreq_t), .we(mwe_t),
    .addr(maddr_t), .wdata(mwd_t), .wmask(mwm_t), .ack(ack_t), .rdata(mrd_t));

  logic        rdy, m_req, m_ack;
  logic [31:0] rdata;
  logic [29:0] m_addr;
  assign rdy    = sel ? rdy_t   : rdy_b;
  assign rdata  = sel ? rdata_t : rdata_b;
  assign m_req  = sel ? mreq_t  : mreq_b;
  assign m_ack  = sel ? ack_t   : ack_b;
  assign m_addr = sel ? maddr_t : maddr_b;

  int total = 0, fails = 0, hold_err = 0;
  logic [31:0] gold [1024];
  logic        sv_valid [64], sv_dirty [64];
  logic [1:0]  sv_tag [64];

  function automatic logic [31:0] pat(int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 1024; i++) gold[i] = pat(i);
    for (int i = 0; i < 64; i++) begin sv_valid[i] = 1'b0; sv_dirty[i] = 1'b0; sv_tag[i] = '0; end
  endtask

  // R5 monitor: a pending request must not drop or move before its acknowledge
  logic        p_req = 1'b0, p_ack = 1'b0;
  logic [29:0] p_addr = '0;
  always @(negedge clk) begin
    if (rst_n && p_req && !p_ack && (!m_req || m_addr != p_addr)) hold_err++;
    p_req <= m_req; p_ack <= m_ack; p_addr <= m_addr;
  end

  function automatic int ntx();
    return sel ? u_mem_t.ntx : u_mem_b.ntx;
  endfunction

  task automatic access(input logic w, input logic [1:0] t, input logic [5:0] ix,
                        input logic [1:0] wd, input logic [31:0] d);
    logic        wbm, hit, vdirty;
    int          gi, tx0, exp_tx, waits;
    logic [31:0] got;
    string       rq;
    wbm    = !sel;
    gi     = {t, ix, wd};
    hit    = sv_valid[ix] && sv_tag[ix] == t;
    vdirty = sv_valid[ix] && sv_dirty[ix];
    if (hit) exp_tx = (w && !wbm) ? 1 : 0;
    else     exp_tx = ((wbm && vdirty) ? 2 : 1) + ((w && !wbm) ? 1 : 0);
    @(negedge clk);
    req = 1'b1; we = w; addr = {18'b0, t, ix, wd, 2'b00}; wdata = d;
    tx0 = ntx();
    #1;
    waits = 0;
    while (!rdy && waits < 2000) begin @(negedge clk); #1; waits++; end
    got = rdata;
    @(posedge clk); #1;
    req = 1'b0;
    if (waits >= 2000) chk(1'b0, "R11 watchdog on access", 32'(waits), 0);
    if (hit && !w) rq = "R3";
    else if (hit && w && wbm) rq = "R7";
    else if (hit && w) rq = "R6";
    else if (wbm && vdirty) rq = "R8";
    else if (w) rq = "R9";
    else if (!wbm) rq = "R10";
    else rq = "R4";
    chk(ntx() - tx0 == exp_tx, {rq, " memory transactions"}, 32'(ntx() - tx0), 32'(exp_tx));
    if (!w) chk(got == gold[gi], {rq, " load data"}, got, gold[gi]);
    if (hit && !(w && !wbm)) chk(waits == 0, {rq, " same-cycle ready"}, 32'(waits), 0);
    if (!hit) chk(waits > 0, "R11 ready low during miss", 32'(waits), 1);
    if (w && !wbm)
      chk(u_mem_t.mem[{t, ix}][wd*32 +: 32] == d, "R6 memory word after store",
          u_mem_t.mem[{t, ix}][wd*32 +: 32], d);
    if (w) gold[gi] = d;
    sv_dirty[ix] = wbm && (w || (hit && sv_dirty[ix]));
    sv_valid[ix] = 1'b1;
    sv_tag[ix]   = t;
  endtask

  task automatic directed();
    access(0, 0, 3, 1, 0);                 // R2 first access after reset misses
    access(0, 0, 3, 1, 0);                 // R3 same word hits
    access(0, 0, 3, 2, 0);                 // R1 other word of same line hits
    access(1, 0, 3, 2, 32'hCAFE0001);      // store hit
    access(0, 0, 3, 2, 0);                 // read back stored word
    access(0, 2, 3, 0, 0);                 // R1 tag conflict: dirty victim in write-back
    access(0, 0, 3, 2, 0);                 // R8 evicted word came back through memory
    access(1, 1, 5, 3, 32'hBEEF0002);      // R9 store miss allocates
    access(0, 1, 5, 3, 0);
    access(0, 3, 5, 3, 0);                 // conflicting load
    access(0, 1, 5, 3, 0);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic w;
      w = ($urandom_range(0, 2) == 0);
      access(w, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 7)),
             2'($urandom_range(0, 3)), $urandom);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; sel = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(!rdy_b && !rdy_t, "R2 ready low after reset", {rdy_b, rdy_t}, 0);
    chk(!mreq_b && !mreq_t, "R2 no memory request after reset", {mreq_b, mreq_t}, 0);
    directed();
    random_run(250);
    sel = 1'b1;
    clear_model();
    directed();
    random_run(250);
    @(negedge clk);
    chk(hold_err == 0, "R5 request held until acknowledge", 32'(hold_err), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule